// File: doc/BRIEF.md
# Block-Splitting DMA Transfer Sequencer

The sequencer takes one DMA transfer at a time, described by a start byte address, a byte count and a direction. It cuts that transfer into memory-side chunks so that no chunk straddles a cache-block boundary. The first chunk may begin part-way into a block. Every later chunk begins on a block boundary. Exactly one chunk is in flight: the sequencer offers a chunk, waits for the memory side to return either the block of read data or a write acknowledgement, and only then offers the next chunk.

A local byte buffer sits behind the sequencer. Read transfers fill it with returned bytes, and write transfers draw their payload from it. The host loads the buffer through a byte port and reads it back through a second byte port. Each accepted transfer receives an identifier from a counter, and that identifier is reported with a one-cycle completion pulse once the last chunk has been answered.

Top module: `dma_chunker`

## Requirements
- R1: After reset, req_ready is 1, cq_valid, done_valid and req_err are 0, done_id is 0, and every buffer byte reads 0.
- R2: req_kind 2'b01 means read and 2'b10 means write. A request offered while idle with kind 2'b00 or 2'b11, with a length of 0, or with a length above MAX_LEN is refused: req_err pulses for one cycle on the cycle after the offer, no chunk is issued and req_ready stays 1.
- R3: req_ready falls on the cycle after a legal request is taken and rises again on the cycle after completion. A request held valid while busy is not taken until req_ready is 1.
- R4: The first chunk has cq_addr equal to the start address, cq_off equal to the start address modulo BLK_BYTES, and cq_len equal to the smaller of the total length and BLK_BYTES minus cq_off. It is offered on the cycle after acceptance.
- R5: Each later chunk has cq_addr equal to the start address plus the bytes completed so far (a multiple of BLK_BYTES), cq_off equal to 0, and cq_len equal to the smaller of the remaining bytes and BLK_BYTES.
- R6: At most one chunk is outstanding. The next chunk is offered on the cycle after the response to the previous one. A response pulse that arrives while idle, or while a chunk is still waiting for cq_ready, is ignored.
- R7: While cq_valid is 1 and cq_ready is 0, cq_valid stays 1 and cq_addr, cq_len and cq_data stay unchanged.
- R8: On a read response, buffer bytes from index (bytes completed) onward, for cq_len bytes, take the bytes of rsp_data starting at byte lane cq_off (lane k is bits 8k+7:8k). The stored bytes are visible on rd_byte.
- R9: For write chunks, cq_write is 1 and cq_data lane k holds buffer byte (bytes completed + k) for k below cq_len, with the other lanes 0. For read chunks, cq_write is 0 and cq_data is all zero. A write acknowledgement advances the transfer in the same way read data does.
- R10: done_valid pulses for one cycle on the cycle after the response that completes the transfer, with done_id carrying the transfer's identifier. Identifiers start at 0 after reset and increase by one per accepted transfer. Refused requests do not consume an identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Idle, a request can be taken |
| req_kind | input | 2 | 01 read, 10 write, other values illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | $clog2(MAX_LEN+1) | Transfer length in bytes |
| req_err | output | 1 | One-cycle pulse for a refused request |
| ld_en | input | 1 | Write one byte into the buffer |
| ld_idx | input | $clog2(MAX_LEN) | Buffer index for ld_byte |
| ld_byte | input | 8 | Byte to store |
| rd_idx | input | $clog2(MAX_LEN) | Buffer index to read |
| rd_byte | output | 8 | Buffer byte at rd_idx |
| cq_valid | output | 1 | Chunk offered to memory |
| cq_ready | input | 1 | Memory takes the chunk |
| cq_write | output | 1 | Chunk is a write |
| cq_addr | output | ADDR_W | Chunk byte address |
| cq_off | output | $clog2(BLK_BYTES) | Offset of the chunk inside its block |
| cq_len | output | $clog2(BLK_BYTES+1) | Chunk length in bytes |
| cq_data | output | 8*BLK_BYTES | Write payload, byte lane k at bits 8k+7:8k |
| rsp_valid | input | 1 | Read data or write acknowledgement |
| rsp_data | input | 8*BLK_BYTES | Returned block for reads |
| done_valid | output | 1 | One-cycle completion pulse |
| done_id | output | ID_W | Identifier of the completed transfer |

## Verification
A corrupted byte counter shows at once in the next chunk's cq_addr or cq_len, which is one cycle after the response, and it also shows as a completion pulse that comes early, comes late or never comes. A wrong state register shows as req_ready or cq_valid out of step with the handshakes on the same cycle. A mis-steered capture lane or a wrong buffer index shows as wrong bytes in the next write payload, or on rd_byte as soon as that index is read. The bench compares every one of these ports against a behavioural model on every cycle, so any of these faults is reported on the first cycle in which it reaches a port.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] KIND_RD = 2'b01;
    localparam logic [1:0] KIND_WR = 2'b10;
endpackage

// File: rtl/dma_chunk_calc.sv
// Derives address, in-block offset and length of the current chunk.
module dma_chunk_calc #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int LEN_W     = 9,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int CL_W     = $clog2(BLK_BYTES + 1),
    localparam int W        = (LEN_W > CL_W) ? LEN_W : CL_W
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  total_len,
    input  logic [LEN_W-1:0]  done_bytes,
    output logic [ADDR_W-1:0] chunk_addr,
    output logic [OFF_W-1:0]  chunk_off,
    output logic [CL_W-1:0]   chunk_len
);
    logic         head;
    logic [W-1:0] remain;
    logic [W-1:0] room;

    always_comb begin
        head       = (done_bytes == '0);
        chunk_off  = head ? start_addr[OFF_W-1:0] : '0;
        remain     = W'(total_len) - W'(done_bytes);
        room       = W'(BLK_BYTES) - W'(chunk_off);
        chunk_len  = (remain < room) ? CL_W'(remain) : CL_W'(room);
        chunk_addr = start_addr + ADDR_W'(done_bytes);
    end
endmodule

// File: rtl/dma_chunk_buf.sv
// Byte buffer: host load/read ports, read-data capture, write payload gather.
module dma_chunk_buf #(
    parameter int BLK_BYTES = 64,
    parameter int DEPTH     = 256,
    parameter int LEN_W     = 9,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int CL_W     = $clog2(BLK_BYTES + 1),
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int BLK_W    = 8 * BLK_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [7:0]       ld_byte,
    input  logic             cap_en,
    input  logic [LEN_W-1:0] cap_base,
    input  logic [OFF_W-1:0] cap_off,
    input  logic [CL_W-1:0]  cap_cnt,
    input  logic [BLK_W-1:0] cap_blk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    input  logic [LEN_W-1:0] gat_base,
    input  logic [CL_W-1:0]  gat_cnt,
    output logic [BLK_W-1:0] gat_blk
);
    logic [7:0]       mem_q [DEPTH];
    logic [7:0]       mem_d [DEPTH];
    int               rel;
    logic [OFF_W-1:0] lane;

    always_comb begin
        rel  = 0;
        lane = '0;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (ld_en && ld_idx == IDX_W'(i)) begin
                mem_d[i] = ld_byte;
            end
            rel  = i - int'(cap_base);
            lane = OFF_W'(rel) + cap_off;
            if (cap_en && rel >= 0 && rel < int'(cap_cnt)) begin
                mem_d[i] = cap_blk[8*lane +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_byte = mem_q[rd_idx];

    for (genvar k = 0; k < BLK_BYTES; k++) begin : g_lane
        assign gat_blk[8*k +: 8] = (CL_W'(k) < gat_cnt)
                                   ? mem_q[IDX_W'(gat_base + LEN_W'(k))] : 8'h00;
    end
endmodule

// File: rtl/dma_chunker.sv
module dma_chunker
    import dma_chunk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int MAX_LEN   = 256,
    parameter int ID_W      = 8,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int CL_W     = $clog2(BLK_BYTES + 1),
    localparam int LEN_W    = $clog2(MAX_LEN + 1),
    localparam int IDX_W    = $clog2(MAX_LEN),
    localparam int BLK_W    = 8 * BLK_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_err,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [7:0]        ld_byte,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte,
    output logic              cq_valid,
    input  logic              cq_ready,
    output logic              cq_write,
    output logic [ADDR_W-1:0] cq_addr,
    output logic [OFF_W-1:0]  cq_off,
    output logic [CL_W-1:0]   cq_len,
    output logic [BLK_W-1:0]  cq_data,
    input  logic              rsp_valid,
    input  logic [BLK_W-1:0]  rsp_data,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  len;
        logic              is_wr;
        logic [LEN_W-1:0]  completed;
        logic [LEN_W-1:0]  issued;
        logic [ID_W-1:0]   cur_id;
        logic [ID_W-1:0]   next_id;
        logic [ID_W-1:0]   done_id;
        logic              done;
        logic              err;
    } seq_t;

    seq_t q, d;

    logic [ADDR_W-1:0] chunk_addr;
    logic [OFF_W-1:0]  chunk_off;
    logic [CL_W-1:0]   chunk_len;
    logic [BLK_W-1:0]  gat_blk;
    logic              legal;
    logic              cap_en;

    dma_chunk_calc #(
        .ADDR_W   (ADDR_W),
        .BLK_BYTES(BLK_BYTES),
        .LEN_W    (LEN_W)
    ) u_calc (
        .start_addr(q.start),
        .total_len (q.len),
        .done_bytes(q.completed),
        .chunk_addr(chunk_addr),
        .chunk_off (chunk_off),
        .chunk_len (chunk_len)
    );

    assign cap_en = (q.st == ST_WAIT) && rsp_valid && !q.is_wr;

    dma_chunk_buf #(
        .BLK_BYTES(BLK_BYTES),
        .DEPTH    (MAX_LEN),
        .LEN_W    (LEN_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_byte (ld_byte),
        .cap_en  (cap_en),
        .cap_base(q.completed),
        .cap_off (chunk_off),
        .cap_cnt (chunk_len),
        .cap_blk (rsp_data),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte),
        .gat_base(q.completed),
        .gat_cnt (chunk_len),
        .gat_blk (gat_blk)
    );

    always_comb begin
        legal = ((req_kind == KIND_RD) || (req_kind == KIND_WR))
                && (req_len != '0) && (req_len <= LEN_W'(MAX_LEN));
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (legal) begin
                        d.st        = ST_ISSUE;
                        d.start     = req_addr;
                        d.len       = req_len;
                        d.is_wr     = (req_kind == KIND_WR);
                        d.completed = '0;
                        d.issued    = '0;
                        d.cur_id    = q.next_id;
                        d.next_id   = q.next_id + 1'b1;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (cq_ready) begin
                    d.issued = q.issued + LEN_W'(chunk_len);
                    d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    d.completed = q.issued;
                    if (q.issued == q.len) begin
                        d.done    = 1'b1;
                        d.done_id = q.cur_id;
                        d.st      = ST_IDLE;
                    end else begin
                        d.st = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign req_err    = q.err;
    assign cq_valid   = (q.st == ST_ISSUE);
    assign cq_write   = cq_valid && q.is_wr;
    assign cq_addr    = chunk_addr;
    assign cq_off     = chunk_off;
    assign cq_len     = chunk_len;
    assign cq_data    = cq_write ? gat_blk : '0;
    assign done_valid = q.done;
    assign done_id    = q.done_id;

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid && !cq_ready |=> cq_valid && $stable(cq_addr)
                                  && $stable(cq_len) && $stable(cq_data));

    // R4 R5
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid |-> ((CL_W+1)'(cq_off) + (CL_W+1)'(cq_len)) <= (CL_W+1)'(BLK_BYTES));

    // R5
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid |-> (cq_addr[OFF_W-1:0] == cq_off) && (cq_len != '0));

    // R3
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid |-> !req_ready);

    // R10
    done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(rsp_valid) && req_ready);

    // R6
    issue_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cq_valid) |-> $past(rsp_valid) || $past(req_valid));
endmodule

// File: tb/dma_chunker_bench.sv
module dma_chunker_bench;
    localparam int BLK  = 64;
    localparam int MAXL = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_kind = 2'b00;
    logic [31:0]  req_addr = '0;
    logic [8:0]   req_len = '0;
    logic         req_err;
    logic         ld_en = 1'b0;
    logic [7:0]   ld_idx = '0;
    logic [7:0]   ld_byte = '0;
    logic [7:0]   rd_idx = '0;
    logic [7:0]   rd_byte;
    logic         cq_valid;
    logic         cq_ready = 1'b0;
    logic         cq_write;
    logic [31:0]  cq_addr;
    logic [5:0]   cq_off;
    logic [6:0]   cq_len;
    logic [511:0] cq_data;
    logic         rsp_valid = 1'b0;
    logic [511:0] rsp_data = '0;
    logic         done_valid;
    logic [7:0]   done_id;

    always #4 clk = ~clk;

    dma_chunker u_dma_chunker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_len(req_len), .req_err(req_err),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_byte(ld_byte),
        .rd_idx(rd_idx), .rd_byte(rd_byte),
        .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_write(cq_write),
        .cq_addr(cq_addr), .cq_off(cq_off), .cq_len(cq_len), .cq_data(cq_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .done_valid(done_valid), .done_id(done_id)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    bit stray_en = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // behavioural model state
    int         m_st = 0;
    int         m_start, m_len, m_comp, m_iss;
    bit         m_wr;
    int         m_id, m_nid, m_did;
    bit         m_done, m_err;
    logic [7:0] mbuf [MAXL];

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic int clen();
        int off, rem, room;
        off  = (m_comp == 0) ? (m_start % BLK) : 0;
        rem  = m_len - m_comp;
        room = BLK - off;
        return (rem < room) ? rem : room;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_nid = 0; m_did = 0; m_done = 0; m_err = 0;
            m_start = 0; m_len = 0; m_comp = 0; m_iss = 0; m_wr = 0; m_id = 0;
            for (int i = 0; i < MAXL; i++) mbuf[i] = 8'h00;
        end else begin
            m_done = 0;
            m_err  = 0;
            if (ld_en) mbuf[ld_idx] = ld_byte;
            case (m_st)
                0: if (req_valid) begin
                    if ((req_kind == 2'b01 || req_kind == 2'b10) && req_len != 0
                        && req_len <= MAXL) begin
                        m_st = 1; m_start = int'(req_addr); m_len = int'(req_len);
                        m_wr = (req_kind == 2'b10); m_comp = 0; m_iss = 0;
                        m_id = m_nid; m_nid = (m_nid + 1) % 256;
                    end else begin
                        m_err = 1;
                    end
                end
                1: if (cq_ready) begin
                    m_iss = m_iss + clen();
                    m_st  = 2;
                end
                2: if (rsp_valid) begin
                    if (!m_wr) begin
                        int so;
                        so = (m_comp == 0) ? (m_start % BLK) : 0;
                        for (int k = 0; k < m_iss - m_comp; k++)
                            mbuf[m_comp + k] = rsp_data[8*(k + so) +: 8];
                    end
                    m_comp = m_iss;
                    if (m_comp == m_len) begin
                        m_done = 1; m_did = m_id; m_st = 0;
                    end else begin
                        m_st = 1;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // memory side: ready throttling, responses and stray pulses
    int dly = 0;
    always @(negedge clk) begin
        cq_ready  = (rnd() % 3) != 0;
        rsp_valid = 1'b0;
        if (m_st == 2) begin
            if (dly == 0) begin
                rsp_valid = 1'b1;
                for (int b = 0; b < BLK; b++) rsp_data[8*b +: 8] = rnd();
                dly = rnd() % 4;
            end else begin
                dly--;
            end
        end else if (stray_en && (rnd() % 5) == 0) begin
            rsp_valid = 1'b1;
            for (int b = 0; b < BLK; b++) rsp_data[8*b +: 8] = rnd();
        end
    end

    // per-cycle comparison against the model
    bit           pv = 0, pr = 0;
    logic [31:0]  pa;
    logic [6:0]   pl;
    logic [511:0] pd;
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            logic [511:0] ed;
            string tg;
            chk(req_ready === (m_st == 0), "R3 req_ready", 512'(req_ready), 512'(m_st == 0));
            chk(cq_valid === (m_st == 1), "R6 cq_valid", 512'(cq_valid), 512'(m_st == 1));
            chk(req_err === m_err, "R2 req_err", 512'(req_err), 512'(m_err));
            chk(done_valid === m_done, "R10 done_valid", 512'(done_valid), 512'(m_done));
            if (m_done) chk(done_id === 8'(m_did), "R10 done_id", 512'(done_id), 512'(m_did));
            chk(rd_byte === mbuf[rd_idx], "R8 rd_byte", 512'(rd_byte), 512'(mbuf[rd_idx]));
            if (m_st == 1) begin
                tg = (m_comp == 0) ? "R4" : "R5";
                chk(cq_addr === 32'(m_start + m_comp), {tg, " cq_addr"}, 512'(cq_addr),
                    512'(m_start + m_comp));
                chk(cq_off === 6'((m_comp == 0) ? (m_start % BLK) : 0), {tg, " cq_off"},
                    512'(cq_off), 512'((m_comp == 0) ? (m_start % BLK) : 0));
                chk(cq_len === 7'(clen()), {tg, " cq_len"}, 512'(cq_len), 512'(clen()));
                ed = '0;
                if (m_wr) for (int k = 0; k < clen(); k++) ed[8*k +: 8] = mbuf[m_comp + k];
                chk(cq_write === m_wr, "R9 cq_write", 512'(cq_write), 512'(m_wr));
                chk(cq_data === ed, "R9 cq_data", cq_data, ed);
            end
            if (pv && !pr) begin
                chk(cq_valid && cq_addr === pa && cq_len === pl && cq_data === pd,
                    "R7 hold", {cq_addr, cq_len}, {pa, pl});
            end
            pv = cq_valid; pr = cq_ready; pa = cq_addr; pl = cq_len; pd = cq_data;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            report();
        end
    end

    task automatic xfer(input logic [1:0] k, input int a, input int l);
        @(negedge clk);
        while (m_st != 0) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = 32'(a); req_len = 9'(l);
        @(negedge clk);
        req_valid = 1'b0;
        while (m_st != 0) @(negedge clk);
    endtask

    task automatic load_buf(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 8'(i); ld_byte = 8'(rnd());
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic sweep();
        for (int i = 0; i < MAXL; i++) begin
            @(negedge clk);
            rd_idx = 8'(i);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(req_ready === 1'b1, "R1 req_ready", 512'(req_ready), 512'(1));
        chk(cq_valid === 1'b0, "R1 cq_valid", 512'(cq_valid), 512'(0));
        chk(done_valid === 1'b0 && done_id === 8'h00, "R1 done", 512'({done_valid, done_id}), 512'(0));
        chk(req_err === 1'b0, "R1 req_err", 512'(req_err), 512'(0));
        chk(rd_byte === 8'h00, "R1 rd_byte", 512'(rd_byte), 512'(0));
        cmp_en   = 1'b1;
        stray_en = 1'b1;
        // reads: aligned, split head, tiny, maximum with 1-byte head
        xfer(2'b01, 'h1000, 64);
        xfer(2'b01, 'h1030, 100);
        xfer(2'b01, 'h10, 5);
        xfer(2'b01, 'h3F, 256);
        sweep();
        // refused requests (R2)
        xfer(2'b00, 'h0, 10);
        xfer(2'b11, 'h80, 10);
        xfer(2'b01, 'h0, 0);
        xfer(2'b10, 'h0, 300);
        // writes from a freshly loaded buffer (R9)
        load_buf(MAXL);
        xfer(2'b10, 'h205, 130);
        xfer(2'b10, 'h7C0, 256);
        xfer(2'b10, 'h40, 1);
        // request held valid across a busy period (R3)
        @(negedge clk);
        while (m_st != 0) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b01; req_addr = 32'h2222; req_len = 9'd70;
        @(negedge clk);
        req_kind = 2'b10; req_addr = 32'h3001; req_len = 9'd40;
        while (m_st != 0) @(negedge clk);
        @(negedge clk);
        while (m_st == 0) @(negedge clk);
        req_valid = 1'b0;
        while (m_st != 0) @(negedge clk);
        xfer(2'b01, 'h5FFF, 200);
        sweep();
        stray_en = 1'b0;
        repeat (5) @(negedge clk);
        report();
    end
endmodule